// File: doc/BRIEF.md
# DRAM Refresh Request Scheduler

This block decides when an asynchronous DRAM must be refreshed and keeps the processor away from the memory while it is. A down-counter, clocked from the system clock, measures the refresh interval. There are two interval presets, a short one and a long one. The interval can be used in two ways. In distributed mode, each expiry asks for one refresh cycle. In burst mode, the timer spans the whole refresh period, which is the row count times the interval, and at each expiry it asks for a refresh of every row, one after another. The RAS/CAS pin sequencing is done elsewhere. That logic takes `rfsh_req`, runs one refresh cycle, and returns a one-cycle `rfsh_done` strobe for each cycle it completes.

A small arbiter shares the memory between refresh and the processor. Refresh always wins, with one exception: a processor access that has already been granted is allowed to finish first. The timer never stops, even while the processor is stalled, so refresh does not depend on software. Distributed intervals that expire before their refresh has been served are not dropped. They are queued in an owed-refresh counter that saturates at a parameterised limit. Both schedules cost the same total refresh time. They differ only in how the processor's stall time is spread out.

Top module: `dram_rfsh_sched`

## Requirements
- R1: While reset is high, and in the cycle after it is released, `rfsh_req`, `cpu_gnt` and `busy` are all 0.
- R2: In distributed mode (`sched_burst`=0) with the short preset (`ivl_ext`=0), successive rising edges of `rfsh_req` are exactly STD_NS×CLK_MHZ/1000 clock cycles apart, and each request is satisfied by one `rfsh_done`.
- R3: With the long preset (`ivl_ext`=1), the spacing of R2 becomes EXT_NS×CLK_MHZ/1000 cycles.
- R4: In burst mode (`sched_burst`=1), `rfsh_req` rises once every ROWS×interval cycles. It then stays high until ROWS `rfsh_done` strobes have been accepted. Once raised, it never falls before a `rfsh_done`.
- R5: `rfsh_req` and `cpu_gnt` are never high in the same cycle.
- R6: When no refresh is owed, a `cpu_req` raised while the arbiter is idle is granted in the next cycle. A grant never starts in the cycle after `busy` was high.
- R7: Once `cpu_gnt` is high it stays high for as long as `cpu_req` stays high, even if refreshes fall due meanwhile. If a refresh is owed, `rfsh_req` rises in the cycle after `cpu_req` drops.
- R8: In distributed mode, intervals that expire without service are queued, up to PEND_MAX (default 8). Exactly min(missed, PEND_MAX) `rfsh_done` strobes are then needed before `rfsh_req` falls.
- R9: `busy` is high whenever a refresh is owed or running, which includes every cycle in which `rfsh_req` is high. It is low once all owed refreshes are done.
- R10: A `rfsh_done` strobe that arrives while `rfsh_req` is low is ignored. `busy` stays 0 and the next refresh still needs its own strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sched_burst | input | 1 | 0 = distributed schedule, 1 = burst schedule; sampled at each timer reload |
| ivl_ext | input | 1 | 0 = short interval preset, 1 = long interval preset; sampled at each timer reload |
| cpu_req | input | 1 | Processor memory access request, held for the whole access |
| rfsh_done | input | 1 | One-cycle strobe: one refresh cycle has completed |
| rfsh_req | output | 1 | Request for the pin sequencer to run a refresh cycle |
| cpu_gnt | output | 1 | Processor access granted |
| busy | output | 1 | A refresh is owed or in progress |

## Verification
Every result is due one cycle after the stimulus that causes it. An expiry, a CPU release or a `rfsh_done` is seen on the next edge, and the output changes right after that edge. The bench drives its inputs and samples outputs on the falling edge. Interval checks compare rise-to-rise spacing of `rfsh_req`, so the fixed one-cycle pipeline drops out of the expected value. Strobe counts are taken from the bench's own responder once `rfsh_req` has fallen.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

    typedef enum logic {
        SCHED_DIST  = 1'b0,
        SCHED_BURST = 1'b1
    } sched_e;

    typedef enum logic [1:0] {
        ARB_IDLE = 2'd0,
        ARB_CPU  = 2'd1,
        ARB_RFSH = 2'd2
    } arb_state_e;

    // clock cycles in an interval given in nanoseconds
    function automatic int unsigned ns_to_cycles(input int unsigned mhz, input int unsigned ns);
        return (mhz * ns) / 1000;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer
    import dram_rfsh_pkg::*;
#(
    parameter int unsigned STD_CYC = 1560,
    parameter int unsigned EXT_CYC = 12500,
    parameter int unsigned ROWS    = 1024,
    parameter int unsigned CNT_W   = 24
) (
    input  logic   clk,
    input  logic   rst,
    input  sched_e mode,
    input  logic   ext_sel,
    output logic   tick
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] reload_m1;
    int unsigned      base_cyc;
    int unsigned      span_cyc;

    // interval length is chosen afresh at every reload
    always_comb begin
        base_cyc  = ext_sel ? EXT_CYC : STD_CYC;
        span_cyc  = (mode == SCHED_BURST) ? base_cyc * ROWS : base_cyc;
        reload_m1 = CNT_W'(span_cyc - 1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= reload_m1;
        else if (cnt == '0)
            cnt <= reload_m1;
        else
            cnt <= cnt - 1'b1;
    end

    assign tick = (cnt == '0);

endmodule

// File: rtl/rfsh_owed_counter.sv
module rfsh_owed_counter
    import dram_rfsh_pkg::*;
#(
    parameter int unsigned ROWS     = 1024,
    parameter int unsigned PEND_MAX = 8,
    parameter int unsigned OWED_W   = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  sched_e            mode,
    input  logic              tick,
    input  logic              rfsh_active,
    input  logic              done,
    output logic [OWED_W-1:0] owed
);
    logic [OWED_W-1:0] after_done;
    logic [OWED_W-1:0] owed_nxt;
    logic              take;

    // a strobe only counts against a request that is actually out
    assign take = done && rfsh_active && (owed != '0);

    always_comb begin
        after_done = take ? owed - 1'b1 : owed;
        owed_nxt   = after_done;
        if (tick) begin
            if (mode == SCHED_BURST)
                owed_nxt = OWED_W'(ROWS);
            else if (after_done >= OWED_W'(PEND_MAX))
                owed_nxt = OWED_W'(PEND_MAX);
            else
                owed_nxt = after_done + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            owed <= '0;
        else
            owed <= owed_nxt;
    end

endmodule

// File: rtl/rfsh_arbiter.sv
module rfsh_arbiter
    import dram_rfsh_pkg::*;
#(
    parameter int unsigned OWED_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              done,
    input  logic              tick,
    input  logic [OWED_W-1:0] owed,
    output logic              rfsh_active,
    output logic              cpu_gnt
);
    arb_state_e state, state_nxt;
    logic       due;
    logic       more_left;

    assign due       = (owed != '0) || tick;
    assign more_left = (owed > OWED_W'(1)) || tick;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ARB_IDLE: begin
                if (due)
                    state_nxt = ARB_RFSH;
                else if (cpu_req)
                    state_nxt = ARB_CPU;
            end
            ARB_CPU: begin
                // a running access is never cut short
                if (!cpu_req)
                    state_nxt = due ? ARB_RFSH : ARB_IDLE;
            end
            ARB_RFSH: begin
                if (done)
                    state_nxt = more_left ? ARB_RFSH : ARB_IDLE;
            end
            default: state_nxt = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= ARB_IDLE;
        else
            state <= state_nxt;
    end

    assign rfsh_active = (state == ARB_RFSH);
    assign cpu_gnt     = (state == ARB_CPU);

endmodule

// File: rtl/dram_rfsh_sched.sv
module dram_rfsh_sched
    import dram_rfsh_pkg::*;
#(
    parameter int unsigned CLK_MHZ  = 100,
    parameter int unsigned STD_NS   = 15600,
    parameter int unsigned EXT_NS   = 125000,
    parameter int unsigned ROWS     = 1024,
    parameter int unsigned PEND_MAX = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic sched_burst,
    input  logic ivl_ext,
    input  logic cpu_req,
    input  logic rfsh_done,
    output logic rfsh_req,
    output logic cpu_gnt,
    output logic busy
);
    localparam int unsigned STD_CYC  = ns_to_cycles(CLK_MHZ, STD_NS);
    localparam int unsigned EXT_CYC  = ns_to_cycles(CLK_MHZ, EXT_NS);
    localparam int unsigned LONGEST  = umax(STD_CYC, EXT_CYC) * ROWS;
    localparam int unsigned CNT_W    = $clog2(LONGEST + 1);
    localparam int unsigned OWED_CAP = umax(ROWS, PEND_MAX);
    localparam int unsigned OWED_W   = $clog2(OWED_CAP + 1);

    sched_e            mode;
    logic              tick;
    logic              rfsh_active;
    logic [OWED_W-1:0] owed_cnt;

    assign mode = sched_e'(sched_burst);

    rfsh_interval_timer #(
        .STD_CYC (STD_CYC),
        .EXT_CYC (EXT_CYC),
        .ROWS    (ROWS),
        .CNT_W   (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .ext_sel (ivl_ext),
        .tick    (tick)
    );

    rfsh_owed_counter #(
        .ROWS     (ROWS),
        .PEND_MAX (PEND_MAX),
        .OWED_W   (OWED_W)
    ) u_owed (
        .clk         (clk),
        .rst         (rst),
        .mode        (mode),
        .tick        (tick),
        .rfsh_active (rfsh_active),
        .done        (rfsh_done),
        .owed        (owed_cnt)
    );

    rfsh_arbiter #(
        .OWED_W (OWED_W)
    ) u_arb (
        .clk         (clk),
        .rst         (rst),
        .cpu_req     (cpu_req),
        .done        (rfsh_done),
        .tick        (tick),
        .owed        (owed_cnt),
        .rfsh_active (rfsh_active),
        .cpu_gnt     (cpu_gnt)
    );

    assign rfsh_req = rfsh_active;
    assign busy     = (owed_cnt != '0);

endmodule

// File: rtl/dram_rfsh_chk.sv
module dram_rfsh_chk #(
    parameter int unsigned OWED_W   = 11,
    parameter int unsigned OWED_CAP = 1024
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_req,
    input logic              rfsh_done,
    input logic              rfsh_req,
    input logic              cpu_gnt,
    input logic              busy,
    input logic [OWED_W-1:0] owed
);
    assert_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(rfsh_req && cpu_gnt));

    assert_no_gnt_when_busy_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_gnt) |-> !$past(busy));

    assert_gnt_held_R7: assert property (@(posedge clk) disable iff (rst)
        (cpu_gnt && cpu_req) |=> cpu_gnt);

    assert_req_until_done_R4: assert property (@(posedge clk) disable iff (rst)
        (rfsh_req && !rfsh_done) |=> rfsh_req);

    assert_req_implies_busy_R9: assert property (@(posedge clk) disable iff (rst)
        rfsh_req |-> busy);

    assert_owed_cap_R8: assert property (@(posedge clk) disable iff (rst)
        owed <= OWED_W'(OWED_CAP));

    assert_stray_done_R10: assert property (@(posedge clk) disable iff (rst)
        (!rfsh_req && !busy && rfsh_done) |=> (owed <= OWED_W'(1)));

endmodule

bind dram_rfsh_sched dram_rfsh_chk #(
    .OWED_W   (OWED_W),
    .OWED_CAP (OWED_CAP)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_req   (cpu_req),
    .rfsh_done (rfsh_done),
    .rfsh_req  (rfsh_req),
    .cpu_gnt   (cpu_gnt),
    .busy      (busy),
    .owed      (owed_cnt)
);

// File: tb/tb_dram_rfsh_sched.sv
module tb_dram_rfsh_sched;

    localparam int CLK_MHZ  = 100;
    localparam int STD_NS   = 200;
    localparam int EXT_NS   = 500;
    localparam int ROWS     = 4;
    localparam int PEND_MAX = 8;
    localparam int STD_CYC  = CLK_MHZ * STD_NS / 1000;   // 20
    localparam int EXT_CYC  = CLK_MHZ * EXT_NS / 1000;   // 50
    localparam int LIMIT    = 2000;

    typedef struct packed {
        logic burst;
        logic ext;
        int   gap;
        int   len;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{1'b0, 1'b0, STD_CYC,        1},
        '{1'b0, 1'b1, EXT_CYC,        1},
        '{1'b1, 1'b0, STD_CYC * ROWS, ROWS},
        '{1'b1, 1'b1, EXT_CYC * ROWS, ROWS}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sched_burst = 1'b0;
    logic ivl_ext = 1'b0;
    logic cpu_req = 1'b0;
    logic man_done = 1'b0;
    logic auto_done = 1'b0;
    logic auto_en = 1'b0;
    logic rfsh_done;
    logic rfsh_req, cpu_gnt, busy;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int done_cnt = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    assign rfsh_done = auto_done | man_done;

    dram_rfsh_sched #(
        .CLK_MHZ  (CLK_MHZ),
        .STD_NS   (STD_NS),
        .EXT_NS   (EXT_NS),
        .ROWS     (ROWS),
        .PEND_MAX (PEND_MAX)
    ) dut (
        .clk         (clk),
        .rst         (rst),
        .sched_burst (sched_burst),
        .ivl_ext     (ivl_ext),
        .cpu_req     (cpu_req),
        .rfsh_done   (rfsh_done),
        .rfsh_req    (rfsh_req),
        .cpu_gnt     (cpu_gnt),
        .busy        (busy)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // refresh sequencer model: one strobe every other cycle while requested
    always @(negedge clk) begin
        if (auto_en && rfsh_req && !auto_done) begin
            auto_done <= 1'b1;
            done_cnt  <= done_cnt + 1;
        end else begin
            auto_done <= 1'b0;
        end
    end

    // R5 observed at the ports on every cycle
    always @(negedge clk) begin
        if (!rst && rfsh_req && cpu_gnt) begin
            n_chk++;
            n_bad++;
            $display("FAIL R5 actual=req&gnt expected=exclusive at cycle %0d", cyc);
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic burst, input logic ext);
        rst = 1'b1;
        sched_burst = burst;
        ivl_ext = ext;
        cpu_req = 1'b0;
        man_done = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_rise(output int at);
        int n = 0;
        while (rfsh_req && n < LIMIT) begin @(negedge clk); n++; end
        while (!rfsh_req && n < LIMIT) begin @(negedge clk); n++; end
        at = cyc;
    endtask

    task automatic wait_fall();
        int n = 0;
        while (rfsh_req && n < LIMIT) begin @(negedge clk); n++; end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        int t0, t1, d0;

        // R1: reset state
        do_reset(1'b0, 1'b0);
        @(negedge clk);
        chk("R1 rfsh_req", int'(rfsh_req), 0);
        chk("R1 cpu_gnt", int'(cpu_gnt), 0);
        chk("R1 busy", int'(busy), 0);

        // R2 R3 R4: schedule table
        foreach (VECS[i]) begin
            do_reset(VECS[i].burst, VECS[i].ext);
            auto_en = 1'b1;
            wait_rise(t0);
            d0 = done_cnt;
            wait_fall();
            chk(VECS[i].burst ? "R4 strobes per episode" : "R2 strobes per request",
                done_cnt - d0, VECS[i].len);
            wait_rise(t1);
            chk(VECS[i].burst ? "R4 period" : (VECS[i].ext ? "R3 interval" : "R2 interval"),
                t1 - t0, VECS[i].gap);
            d0 = done_cnt;
            wait_fall();
            chk(VECS[i].burst ? "R4 strobes repeat" : "R2 strobes repeat",
                done_cnt - d0, VECS[i].len);
            auto_en = 1'b0;
        end

        // R10: stray strobe while nothing requested
        do_reset(1'b0, 1'b0);
        @(negedge clk);
        man_done = 1'b1;
        @(negedge clk);
        man_done = 1'b0;
        @(negedge clk);
        chk("R10 busy after stray strobe", int'(busy), 0);
        chk("R10 req after stray strobe", int'(rfsh_req), 0);
        wait_rise(t0);
        repeat (3) @(negedge clk);
        chk("R10 request still pending", int'(rfsh_req), 1);

        // R8: missed intervals queue and saturate
        do_reset(1'b0, 1'b1);
        wait_rise(t0);
        repeat (9 * EXT_CYC) @(negedge clk);
        chk("R9 busy while owed", int'(busy), 1);
        d0 = done_cnt;
        auto_en = 1'b1;
        wait_fall();
        chk("R8 saturated backlog", done_cnt - d0, PEND_MAX);
        @(negedge clk);
        chk("R9 busy clear after drain", int'(busy), 0);
        auto_en = 1'b0;

        // R6 R7: granted access is finished before refresh
        do_reset(1'b0, 1'b0);
        auto_en = 1'b1;
        @(negedge clk);
        cpu_req = 1'b1;
        @(negedge clk);
        chk("R6 grant one cycle after request", int'(cpu_gnt), 1);
        begin
            int lost = 0;
            for (int k = 0; k < 3 * STD_CYC + 5; k++) begin
                @(negedge clk);
                if (!cpu_gnt || rfsh_req) lost++;
            end
            chk("R7 grant held across expiries", lost, 0);
        end
        chk("R9 busy while cpu holds", int'(busy), 1);
        d0 = done_cnt;
        cpu_req = 1'b0;
        @(negedge clk);
        chk("R7 refresh right after release", int'(rfsh_req), 1);
        chk("R7 grant dropped", int'(cpu_gnt), 0);
        cpu_req = 1'b1;
        begin
            int n = 0;
            while (!cpu_gnt && n < LIMIT) begin @(negedge clk); n++; end
        end
        chk("R6 new grant only after drain", int'(busy), 0);
        chk("R7 queued refreshes served", done_cnt - d0, 3);
        cpu_req = 1'b0;
        auto_en = 1'b0;
        repeat (2) @(negedge clk);

        summary();
    end

endmodule